// File: doc/BRIEF.md
# DMA Peripheral Request Router

This block sits in front of one DMA channel. It decides when that channel starts a transfer in response to level-style request lines from on-chip peripherals. The peripherals are two serial ports, each with a transmit-empty and a receive-full line, and one timer input-capture event. A 4-bit select code picks the request line. The same code also fixes which transfer endpoint must be the serial port's data register, and which bus modes are legal.

Before any request is passed on, the router checks the programmed source class, destination class and bus mode against the rules that the select code implies. A bad setup raises a configuration-error flag and blocks all starts. A good setup allows one start strobe for each rising edge of the selected line, provided every channel and controller enable condition holds. After a strobe, no new strobe is issued until an acknowledge marks the transfer complete. The router also reports which serial data register is forced as an endpoint and the bus mode that takes effect.

Top module: `dmarq_router`

## Requirements
- R1: While `rst` (synchronous, active high) is 1, on the next clock edge `start_o`, `cfg_err_o`, `regsel_o` and `mode_o` all become 0, and the internal edge and busy state is cleared.
- R2: `start_o` is 1 for exactly one cycle. It rises on the clock edge after the edge at which the selected request line is first sampled at 1, following a sample at 0, with all other conditions met.
- R3: A start is issued only when `ch_en_i`=1, `dma_en_i`=1, `xfer_end_i`=0, `nmi_flag_i`=0 and `addr_err_i`=0.
- R4: After a start, further rising edges on the selected line are ignored until `ack_i` is sampled at 1. The first rising edge after that produces a new start.
- R5: If any enable condition of R3 fails, the outstanding transfer is forgotten. A request line that stays high while the channel is re-enabled produces no start. Only a new rising edge does.
- R6: Codes 4'b1001 (port 1 receive-full, line 1) and 4'b1011 (port 2 receive-full, line 3) require source class 2 (serial data register) and destination class 0 (external memory). Codes 4'b1000 (port 1 transmit-empty, line 0) and 4'b1010 (port 2 transmit-empty, line 2) require source class 0 and destination class 2.
- R7: `burst_i`=1 (burst) with a serial code 4'b1000 to 4'b1011 is a configuration error, and `mode_o` is then 0 (cycle steal). With a timer code, `mode_o` follows `burst_i`. With any other code, `mode_o` is 0.
- R8: Codes 4'b1100, 4'b1101 and 4'b1110 all select the timer capture line (line 4). Their required source/destination classes are 0/0, 0/1 (1 = on-chip peripheral) and 1/0 respectively.
- R9: `cfg_err_o` is 1 in the cycle after a code outside 4'b1000 to 4'b1110, a class mismatch, or an illegal burst is sampled. `start_o` is never 1 when the same sample sets `cfg_err_o`. Class value 3 always mismatches.
- R10: `regsel_o` reports the forced endpoint: 0 none (timer or invalid code), 1 destination is port 1 transmit data, 2 source is port 1 receive data, 3 destination is port 2 transmit data, 4 source is port 2 receive data.
- R11: Request lines other than the one the code selects have no effect on `start_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_sel_i | input | 4 | Request select code |
| preq_i | input | 5 | Request lines: 0 p1 tx-empty, 1 p1 rx-full, 2 p2 tx-empty, 3 p2 rx-full, 4 timer capture |
| ch_en_i | input | 1 | Channel enable |
| dma_en_i | input | 1 | Controller master enable |
| xfer_end_i | input | 1 | Transfer-end flag |
| nmi_flag_i | input | 1 | NMI flag |
| addr_err_i | input | 1 | Address-error flag |
| src_class_i | input | 2 | Programmed source class (0 ext mem, 1 on-chip periph, 2 serial data reg, 3 reserved) |
| dst_class_i | input | 2 | Programmed destination class (same encoding) |
| burst_i | input | 1 | Programmed bus mode: 1 burst, 0 cycle steal |
| ack_i | input | 1 | Current transfer complete |
| start_o | output | 1 | One-cycle transfer-start strobe |
| regsel_o | output | 3 | Forced serial data register selection |
| mode_o | output | 1 | Effective bus mode: 1 burst |
| cfg_err_o | output | 1 | Configuration error |

## Verification
The bench targets several corner cases:
- A request line held high across a disable and re-enable. A router that replays on re-enable would emit an extra strobe.
- Bursts of edges before the acknowledge. A router without the busy hold would start twice.
- Requests toggling on unselected lines. A mux that is wrong by one line, or OR-reduces all lines, would start spuriously.
- Each serial code combined with burst mode or swapped endpoint classes, and each of the three timer class pairs. A decoder that confuses receive with transmit, or treats the three timer codes alike, would flag good setups or pass bad ones.

Random configurations and request toggles around these cases are compared against a cycle model computed from the rules.

// File: rtl/dmarq_pkg.sv
package dmarq_pkg;

    localparam int SEL_W   = 4;
    localparam int NUM_REQ = 5;
    localparam int LINE_W  = $clog2(NUM_REQ);

    localparam logic [LINE_W-1:0] LN_P1_TXE = 0;
    localparam logic [LINE_W-1:0] LN_P1_RXF = 1;
    localparam logic [LINE_W-1:0] LN_P2_TXE = 2;
    localparam logic [LINE_W-1:0] LN_P2_RXF = 3;
    localparam logic [LINE_W-1:0] LN_TMR    = 4;

    typedef enum logic [1:0] {
        EP_EXTMEM  = 2'd0,
        EP_ONCHIP  = 2'd1,
        EP_SERDATA = 2'd2,
        EP_RSVD    = 2'd3
    } ep_class_e;

    typedef enum logic [2:0] {
        RS_NONE     = 3'd0,
        RS_DST_P1TX = 3'd1,
        RS_SRC_P1RX = 3'd2,
        RS_DST_P2TX = 3'd3,
        RS_SRC_P2RX = 3'd4
    } regsel_e;

    typedef struct packed {
        logic              valid;
        logic [LINE_W-1:0] line;
        ep_class_e         src;
        ep_class_e         dst;
        logic              burst_ok;
        regsel_e           regsel;
    } rule_t;

    function automatic rule_t rule_of(input logic [SEL_W-1:0] code);
        rule_t r;
        r = '{valid: 1'b0, line: '0, src: EP_RSVD, dst: EP_RSVD,
              burst_ok: 1'b0, regsel: RS_NONE};
        case (code)
            4'b1000: r = '{1'b1, LN_P1_TXE, EP_EXTMEM,  EP_SERDATA, 1'b0, RS_DST_P1TX};
            4'b1001: r = '{1'b1, LN_P1_RXF, EP_SERDATA, EP_EXTMEM,  1'b0, RS_SRC_P1RX};
            4'b1010: r = '{1'b1, LN_P2_TXE, EP_EXTMEM,  EP_SERDATA, 1'b0, RS_DST_P2TX};
            4'b1011: r = '{1'b1, LN_P2_RXF, EP_SERDATA, EP_EXTMEM,  1'b0, RS_SRC_P2RX};
            4'b1100: r = '{1'b1, LN_TMR,    EP_EXTMEM,  EP_EXTMEM,  1'b1, RS_NONE};
            4'b1101: r = '{1'b1, LN_TMR,    EP_EXTMEM,  EP_ONCHIP,  1'b1, RS_NONE};
            4'b1110: r = '{1'b1, LN_TMR,    EP_ONCHIP,  EP_EXTMEM,  1'b1, RS_NONE};
            default: ;
        endcase
        return r;
    endfunction

    function automatic logic enable_ok(input logic ch_en, input logic dma_en,
                                       input logic xend, input logic nmi,
                                       input logic aerr);
        return ch_en & dma_en & ~xend & ~nmi & ~aerr;
    endfunction

endpackage

// File: rtl/dmarq_decode.sv
module dmarq_decode
    import dmarq_pkg::*;
(
    input  logic [SEL_W-1:0] sel,
    output rule_t            rule
);
    always_comb rule = rule_of(sel);
endmodule

// File: rtl/dmarq_check.sv
module dmarq_check
    import dmarq_pkg::*;
(
    input  rule_t     rule,
    input  ep_class_e src,
    input  ep_class_e dst,
    input  logic      burst,
    output logic      cfg_bad,
    output logic      eff_burst
);
    logic ep_bad;
    logic mode_bad;

    always_comb begin
        ep_bad    = (src != rule.src) | (dst != rule.dst) |
                    (src == EP_RSVD) | (dst == EP_RSVD);
        mode_bad  = burst & ~rule.burst_ok;
        cfg_bad   = ~rule.valid | ep_bad | mode_bad;
        eff_burst = rule.valid & rule.burst_ok & burst;
    end
endmodule

// File: rtl/dmarq_trigger.sv
module dmarq_trigger
    import dmarq_pkg::*;
#(
    parameter int N  = NUM_REQ,
    parameter int LW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  preq,
    input  logic          rule_valid,
    input  logic [LW-1:0] line,
    input  logic          en_ok,
    input  logic          cfg_bad,
    input  logic          ack,
    output logic          start_q
);
    logic [N-1:0] hit;
    logic lvl, prev_q, busy_q, rise, fire;

    for (genvar i = 0; i < N; i++) begin : g_line
        assign hit[i] = preq[i] & (line == LW'(i));
    end

    always_comb begin
        lvl  = rule_valid & (|hit);
        rise = lvl & ~prev_q;
        fire = rise & en_ok & ~cfg_bad & ~busy_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= 1'b0;
            busy_q  <= 1'b0;
            start_q <= 1'b0;
        end else begin
            prev_q  <= lvl;
            start_q <= fire;
            if (busy_q) busy_q <= ~(ack | ~en_ok);
            else        busy_q <= fire;
        end
    end

    p_one_shot_r2: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    p_from_edge_r2: assert property (@(posedge clk) disable iff (rst)
        start_q |-> $past(rise));

    p_hold_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (busy_q && en_ok && !ack) |=> (busy_q && !start_q));

    p_drop_clears_r5: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !en_ok) |=> !busy_q);
endmodule

// File: rtl/dmarq_router.sv
module dmarq_router
    import dmarq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SEL_W-1:0] req_sel_i,
    input  logic [NUM_REQ-1:0] preq_i,
    input  logic             ch_en_i,
    input  logic             dma_en_i,
    input  logic             xfer_end_i,
    input  logic             nmi_flag_i,
    input  logic             addr_err_i,
    input  logic [1:0]       src_class_i,
    input  logic [1:0]       dst_class_i,
    input  logic             burst_i,
    input  logic             ack_i,
    output logic             start_o,
    output logic [2:0]       regsel_o,
    output logic             mode_o,
    output logic             cfg_err_o
);
    rule_t rule;
    logic  cfg_bad, eff_burst, en_ok;

    dmarq_decode i_decode (.sel(req_sel_i), .rule(rule));

    dmarq_check i_check (
        .rule      (rule),
        .src       (ep_class_e'(src_class_i)),
        .dst       (ep_class_e'(dst_class_i)),
        .burst     (burst_i),
        .cfg_bad   (cfg_bad),
        .eff_burst (eff_burst)
    );

    always_comb en_ok = enable_ok(ch_en_i, dma_en_i, xfer_end_i, nmi_flag_i, addr_err_i);

    dmarq_trigger #(.N(NUM_REQ), .LW(LINE_W)) i_trigger (
        .clk        (clk),
        .rst        (rst),
        .preq       (preq_i),
        .rule_valid (rule.valid),
        .line       (rule.line),
        .en_ok      (en_ok),
        .cfg_bad    (cfg_bad),
        .ack        (ack_i),
        .start_q    (start_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            regsel_o  <= RS_NONE;
            mode_o    <= 1'b0;
            cfg_err_o <= 1'b0;
        end else begin
            regsel_o  <= rule.regsel;
            mode_o    <= eff_burst;
            cfg_err_o <= cfg_bad;
        end
    end

    p_err_no_start_r9: assert property (@(posedge clk) disable iff (rst)
        start_o |-> !cfg_err_o);

    p_bad_code_r9: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ($past(req_sel_i) < 4'b1000 || $past(req_sel_i) == 4'b1111))
        |-> cfg_err_o);

    p_serial_cs_r7: assert property (@(posedge clk) disable iff (rst)
        (regsel_o != 3'd0) |-> !mode_o);

    p_start_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
        start_o |-> $past(en_ok));
endmodule

// File: tb/test_dmarq_router.sv
`timescale 1ns/1ps
module test_dmarq_router;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] req_sel = 4'b1000;
    logic [4:0] preq = '0;
    logic ch_en = 0, dma_en = 0, xend = 0, nmi = 0, aerr = 0;
    logic [1:0] src_c = 0, dst_c = 0;
    logic burst = 0, ack = 0;
    logic start_o, mode_o, cfg_err_o;
    logic [2:0] regsel_o;

    int checks = 0, errors = 0;
    bit m_prev = 0, m_busy = 0;
    bit e_start = 0, e_err = 0, e_mode = 0;
    int e_regsel = 0;

    always #2.5 clk = ~clk;

    dmarq_router i_dmarq_router (
        .clk(clk), .rst(rst), .req_sel_i(req_sel), .preq_i(preq),
        .ch_en_i(ch_en), .dma_en_i(dma_en), .xfer_end_i(xend),
        .nmi_flag_i(nmi), .addr_err_i(aerr), .src_class_i(src_c),
        .dst_class_i(dst_c), .burst_i(burst), .ack_i(ack),
        .start_o(start_o), .regsel_o(regsel_o), .mode_o(mode_o),
        .cfg_err_o(cfg_err_o)
    );

    // R6 R8: required classes; R10 register selection
    function automatic bit code_ok(input logic [3:0] c);
        return c >= 4'b1000 && c <= 4'b1110;
    endfunction
    function automatic int line_of(input logic [3:0] c);
        return (c >= 4'b1100) ? 4 : int'(c[1:0]);
    endfunction
    function automatic int req_src(input logic [3:0] c);
        case (c)
            4'b1001, 4'b1011: return 2;
            4'b1110:          return 1;
            default:          return 0;
        endcase
    endfunction
    function automatic int req_dst(input logic [3:0] c);
        case (c)
            4'b1000, 4'b1010: return 2;
            4'b1101:          return 1;
            default:          return 0;
        endcase
    endfunction
    function automatic int regsel_of(input logic [3:0] c);
        return (c >= 4'b1000 && c <= 4'b1011) ? int'(c[1:0]) + 1 : 0;
    endfunction

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // one clock: model the edge, then compare outputs at the next negedge
    task automatic step(input string tag);
        bit ok, ser, err, lvl, en, st;
        ok  = code_ok(req_sel);
        ser = ok && req_sel <= 4'b1011;
        err = !ok || (int'(src_c) != req_src(req_sel)) || (int'(dst_c) != req_dst(req_sel))
              || src_c == 2'd3 || dst_c == 2'd3 || (burst && ser);
        lvl = ok && preq[line_of(req_sel)];
        en  = ch_en && dma_en && !xend && !nmi && !aerr;
        st  = lvl && !m_prev && en && !err && !m_busy;
        if (rst) begin
            e_start = 0; e_err = 0; e_mode = 0; e_regsel = 0; m_prev = 0; m_busy = 0;
        end else begin
            e_start  = st;
            e_err    = err;
            e_mode   = ok && !ser && burst;
            e_regsel = regsel_of(req_sel);
            m_busy   = m_busy ? !(ack || !en) : st;
            m_prev   = lvl;
        end
        @(posedge clk);
        @(negedge clk);
        cmp(tag, "start_o", int'(start_o), int'(e_start));
        cmp(tag, "cfg_err_o", int'(cfg_err_o), int'(e_err));
        cmp(tag, "mode_o", int'(mode_o), int'(e_mode));
        cmp(tag, "regsel_o", int'(regsel_o), e_regsel);
    endtask

    task automatic setup(input logic [3:0] c, input bit b);
        req_sel = c;
        src_c   = 2'(req_src(c));
        dst_c   = 2'(req_dst(c));
        burst   = b;
    endtask

    task automatic enable_all();
        ch_en = 1; dma_en = 1; xend = 0; nmi = 0; aerr = 0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = 7;
        void'($urandom(seed));
        @(negedge clk);
        rst = 1; preq = 5'h1f; enable_all(); setup(4'b1100, 0);
        step("R1"); step("R1");
        rst = 0; preq = 0;
        step("R1");

        // R2 basic edge per code, R8 timer class pairs, R10 selection
        for (int c = 8; c <= 14; c++) begin
            setup(4'(c), c >= 12);
            ack = 0; preq = 0; step("R8");
            preq[line_of(4'(c))] = 1; step("R2"); step("R2");
            ack = 1; preq = 0; step("R10"); ack = 0;
        end

        // R11: unselected lines toggle
        setup(4'b1001, 0); preq = 0; step("R11");
        preq = 5'b11101; step("R11"); preq = 0; step("R11"); preq = 5'b11101; step("R11");

        // R4: second edge before ack ignored, then ack reopens
        preq = 5'b00010; step("R4"); preq = 0; step("R4");
        preq = 5'b00010; step("R4"); preq = 0; ack = 1; step("R4"); ack = 0;
        preq = 5'b00010; step("R4"); ack = 1; step("R4"); ack = 0;

        // R5/R3: held level across disable, no replay
        preq = 0; step("R5"); preq = 5'b00010; ch_en = 0; step("R3");
        ch_en = 1; step("R5"); step("R5");
        preq = 0; ack = 1; step("R5"); ack = 0;
        nmi = 1; preq = 5'b00010; step("R3"); nmi = 0; step("R5");
        preq = 0; step("R5"); preq = 5'b00010; step("R5"); preq = 0; ack = 1; step("R5"); ack = 0;

        // R6/R7/R9 bad setups
        setup(4'b1000, 1); preq = 0; step("R7"); preq = 1; step("R7");
        setup(4'b1001, 0); src_c = 0; dst_c = 2; preq = 0; step("R6"); preq = 2; step("R6");
        setup(4'b1100, 0); src_c = 3; dst_c = 3; step("R9");
        req_sel = 4'b1111; preq = 5'h1f; step("R9"); req_sel = 4'b0011; step("R9");
        preq = 0; ack = 1; step("R9"); ack = 0;

        // random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom_range(0, 15) == 0) begin
                int c;
                c = ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 15)) : int'($urandom_range(8, 14));
                setup(4'(c), 1'($urandom_range(0, 1)));
                if ($urandom_range(0, 4) == 0) src_c = 2'($urandom_range(0, 3));
                if ($urandom_range(0, 4) == 0) dst_c = 2'($urandom_range(0, 3));
            end
            ch_en  = $urandom_range(0, 19) != 0;
            dma_en = $urandom_range(0, 29) != 0;
            xend   = $urandom_range(0, 29) == 0;
            nmi    = $urandom_range(0, 39) == 0;
            aerr   = $urandom_range(0, 39) == 0;
            for (int b = 0; b < 5; b++)
                if ($urandom_range(0, 3) == 0) preq[b] = ~preq[b];
            ack = $urandom_range(0, 4) == 0;
            rst = $urandom_range(0, 499) == 0;
            step(rst ? "R1" : "R2");
        end
        rst = 0;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule